// File: doc/BRIEF.md
# Daisy-Chained Vectored Interrupt Responder

This block is the interrupt front end of one peripheral that shares a single interrupt request level with other peripherals. Inside the peripheral, an event pulse sets a pending flag. The flag drives an active-low request line and stays set until software clears it. Software loads an 8-bit vector number through a simple write port. Until that first write, the register holds 0x0F, the number that selects the uninitialised-interrupt exception.

When the host acknowledges the shared level, an active-low acknowledge travels down a chain of these blocks. Each block samples the falling edge of its incoming acknowledge and makes one fixed choice for the whole acknowledge cycle:
- If it is requesting at that edge, it claims the cycle. It drives the vector onto the data bus with an output enable and asserts the active-low transfer acknowledge.
- If it is not requesting, it passes the acknowledge on to the next block.

Because of this, the block nearest the acknowledge source wins, and exactly one block answers. Every output is released one clock after the incoming acknowledge returns high.

Top module: `irq_chain_node`

## Requirements
- R1: After reset, req_n=1, ack_out_n=1, bus_oe=0, dtack_n=1 and bus_data=0, and the vector register holds 0x0F.
- R2: A raise pulse makes req_n low on the next clock. req_n stays low across acknowledge cycles until a clear pulse, which makes req_n high on the next clock. When raise and clear arrive together, raise wins.
- R3: A value written through the vector port is the one driven on bus_data at the next claim.
- R4: If the vector register was never written since reset, a claim drives 0x0F.
- R5: When ack_in_n is sampled low after being high and req_n is low, then on the next clock bus_oe=1, dtack_n=0, bus_data holds the vector, and ack_out_n stays 1.
- R6: When ack_in_n is sampled low after being high and req_n is high, then on the next clock ack_out_n=0, bus_oe=0 and dtack_n=1.
- R7: The claim-or-pass choice holds while ack_in_n stays low. A raise during a passed cycle does not start a claim, and a clear during a claimed cycle does not end it.
- R8: One clock after ack_in_n is sampled high, bus_oe=0, dtack_n=1 and ack_out_n=1.
- R9: bus_data is 0 whenever bus_oe is 0. While bus_oe is 1, bus_data stays stable even if the vector is rewritten.
- R10: In a chain, the requesting block nearest the acknowledge source claims the cycle, and no other block asserts dtack_n. If no block requests, the acknowledge leaves the last block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vec_wr_en | input | 1 | Write strobe for the vector register |
| vec_wr_data | input | 8 | Vector value to write |
| raise_req | input | 1 | Internal event: set the pending flag |
| clr_req | input | 1 | Software clear of the pending flag |
| req_n | output | 1 | Active-low interrupt request |
| ack_in_n | input | 1 | Active-low acknowledge from the previous block |
| ack_out_n | output | 1 | Active-low acknowledge to the next block |
| bus_data | output | 8 | Vector number while claiming, else 0 |
| bus_oe | output | 1 | Data bus output enable |
| dtack_n | output | 1 | Active-low transfer acknowledge |

## Verification
On every cycle, the assertions check the following:
- the one-clock claim or pass response to an acknowledge edge, chosen by the request line;
- that the choice is held while the acknowledge stays low;
- that all outputs are released one clock after the acknowledge rises;
- that the data bus stays stable during a claim;
- how the request line reacts to raise and clear.

Only the bench scenarios can show the following:
- that the vector value actually driven matches the last write or the 0x0F default;
- that pending survives acknowledge cycles;
- that a three-block chain picks the nearest requester, or lets the acknowledge fall off the end.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CLAIM = 2'd1,
    ST_PASS  = 2'd2
  } ack_state_e;

  // Choice taken at the acknowledge falling edge.
  function automatic ack_state_e ack_choice(input logic pending);
    return pending ? ST_CLAIM : ST_PASS;
  endfunction

  // Pending flag update: a raise beats a clear so no event is lost.
  function automatic logic pend_update(input logic cur, input logic set, input logic clr);
    if (set)      return 1'b1;
    else if (clr) return 1'b0;
    else          return cur;
  endfunction

endpackage

// File: rtl/irq_vec_reg.sv
module irq_vec_reg #(
  parameter int         VEC_W   = 8,
  parameter logic [VEC_W-1:0] RST_VAL = 'h0F
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [VEC_W-1:0] wr_data,
  output logic [VEC_W-1:0] vec
);
  always_ff @(posedge clk) begin
    if (!rst_n)     vec <= RST_VAL;
    else if (wr_en) vec <= wr_data;
  end
endmodule

// File: rtl/irq_pend_flag.sv
module irq_pend_flag
  import irq_chain_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic pending
);
  always_ff @(posedge clk) begin
    if (!rst_n) pending <= 1'b0;
    else        pending <= pend_update(pending, set, clr);
  end
endmodule

// File: rtl/irq_ack_ctrl.sv
module irq_ack_ctrl
  import irq_chain_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ack_in_n,
  input  logic             pending,
  input  logic [VEC_W-1:0] vec,
  output logic             ack_fall,
  output logic             claiming,
  output logic             passing,
  output logic [VEC_W-1:0] held_vec
);
  logic       ack_q;
  ack_state_e state_q;

  assign ack_fall = ack_q & ~ack_in_n;
  assign claiming = (state_q == ST_CLAIM);
  assign passing  = (state_q == ST_PASS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_q    <= 1'b1;
      state_q  <= ST_IDLE;
      held_vec <= '0;
    end else begin
      ack_q <= ack_in_n;
      if (ack_in_n) begin
        state_q <= ST_IDLE;
      end else if (ack_fall) begin
        state_q <= ack_choice(pending);
        if (pending) held_vec <= vec;
      end
    end
  end
endmodule

// File: rtl/irq_chain_node.sv
module irq_chain_node #(
  parameter int               VEC_W      = 8,
  parameter logic [VEC_W-1:0] UNINIT_VEC = 'h0F
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vec_wr_en,
  input  logic [VEC_W-1:0] vec_wr_data,
  input  logic             raise_req,
  input  logic             clr_req,
  output logic             req_n,
  input  logic             ack_in_n,
  output logic             ack_out_n,
  output logic [VEC_W-1:0] bus_data,
  output logic             bus_oe,
  output logic             dtack_n
);
  logic [VEC_W-1:0] vec_cur;
  logic [VEC_W-1:0] vec_held;
  logic             pending;
  logic             ack_fall;
  logic             claiming;
  logic             passing;

  irq_vec_reg #(.VEC_W(VEC_W), .RST_VAL(UNINIT_VEC)) u_vec (
    .clk(clk), .rst_n(rst_n), .wr_en(vec_wr_en), .wr_data(vec_wr_data), .vec(vec_cur)
  );

  irq_pend_flag u_pend (
    .clk(clk), .rst_n(rst_n), .set(raise_req), .clr(clr_req), .pending(pending)
  );

  irq_ack_ctrl #(.VEC_W(VEC_W)) u_ack (
    .clk(clk), .rst_n(rst_n), .ack_in_n(ack_in_n), .pending(pending), .vec(vec_cur),
    .ack_fall(ack_fall), .claiming(claiming), .passing(passing), .held_vec(vec_held)
  );

  assign req_n     = ~pending;
  assign ack_out_n = ~passing;
  assign bus_oe    = claiming;
  assign dtack_n   = ~claiming;
  assign bus_data  = claiming ? vec_held : '0;
endmodule

// File: rtl/irq_chain_node_chk.sv
module irq_chain_node_chk #(
  parameter int VEC_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             raise_req,
  input logic             clr_req,
  input logic             req_n,
  input logic             ack_in_n,
  input logic             ack_out_n,
  input logic [VEC_W-1:0] bus_data,
  input logic             bus_oe,
  input logic             dtack_n
);
  p_set_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (raise_req || (!req_n && !clr_req)) |=> !req_n);

  p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !raise_req) |=> req_n);

  p_claim_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ack_in_n) && !req_n) |=> (bus_oe && !dtack_n && ack_out_n));

  p_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ack_in_n) && req_n) |=> (!ack_out_n && !bus_oe && dtack_n));

  p_pass_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_out_n && !ack_in_n) |=> (!ack_out_n && !bus_oe));

  p_claim_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && !ack_in_n) |=> (bus_oe && $stable(bus_data)));

  p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ack_in_n |=> (!bus_oe && dtack_n && ack_out_n));
endmodule

bind irq_chain_node irq_chain_node_chk #(.VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .raise_req(raise_req), .clr_req(clr_req), .req_n(req_n),
  .ack_in_n(ack_in_n), .ack_out_n(ack_out_n), .bus_data(bus_data), .bus_oe(bus_oe),
  .dtack_n(dtack_n)
);

// File: tb/sim_irq_chain_node.sv
`timescale 1ns/1ps
module sim_irq_chain_node;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [2:0] raise = '0, clr = '0, wen = '0;
  logic [7:0] wd [3];
  logic       ack_src = 1'b1;
  wire  [2:0] reqn, ao, oe, dtn;
  wire  [7:0] bd [3];

  irq_chain_node u0 (.clk(clk), .rst_n(rst_n), .vec_wr_en(wen[0]), .vec_wr_data(wd[0]),
    .raise_req(raise[0]), .clr_req(clr[0]), .req_n(reqn[0]), .ack_in_n(ack_src),
    .ack_out_n(ao[0]), .bus_data(bd[0]), .bus_oe(oe[0]), .dtack_n(dtn[0]));
  irq_chain_node u1 (.clk(clk), .rst_n(rst_n), .vec_wr_en(wen[1]), .vec_wr_data(wd[1]),
    .raise_req(raise[1]), .clr_req(clr[1]), .req_n(reqn[1]), .ack_in_n(ao[0]),
    .ack_out_n(ao[1]), .bus_data(bd[1]), .bus_oe(oe[1]), .dtack_n(dtn[1]));
  irq_chain_node u2 (.clk(clk), .rst_n(rst_n), .vec_wr_en(wen[2]), .vec_wr_data(wd[2]),
    .raise_req(raise[2]), .clr_req(clr[2]), .req_n(reqn[2]), .ack_in_n(ao[1]),
    .ack_out_n(ao[2]), .bus_data(bd[2]), .bus_oe(oe[2]), .dtack_n(dtn[2]));

  int n_tests = 0, n_fail = 0;
  logic       m_pend [3];
  logic [7:0] m_vec  [3];
  bit         finished = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  function automatic int winner();
    for (int i = 0; i < 3; i++) if (m_pend[i]) return i;
    return 3;
  endfunction

  function automatic logic pend_ref(input logic cur, input logic r, input logic c);
    return r ? 1'b1 : (c ? 1'b0 : cur);
  endfunction

  task automatic pulse(input int i, input logic r, input logic c);
    raise[i] = r; clr[i] = c;
    step();
    raise[i] = 0; clr[i] = 0;
    m_pend[i] = pend_ref(m_pend[i], r, c);
    check($sformatf("R2 req_n dev%0d", i), reqn[i], !m_pend[i]);
  endtask

  task automatic write_vec(input int i, input logic [7:0] v);
    wen[i] = 1; wd[i] = v;
    step();
    wen[i] = 0;
    m_vec[i] = v;
  endtask

  task automatic do_ack();
    int w = winner();
    ack_src = 0;
    step();
    if (w == 0) begin
      check("R5 oe after one clock", oe[0], 1);
      check("R5 dtack_n", dtn[0], 0);
      check("R5 ack_out_n held", ao[0], 1);
    end else begin
      check("R6 ack_out_n after one clock", ao[0], 0);
      check("R6 oe", oe[0], 0);
    end
    step(); step();
    for (int i = 0; i < 3; i++) begin
      check($sformatf("R10 oe dev%0d", i), oe[i], i == w);
      check($sformatf("R10 dtack_n dev%0d", i), dtn[i], !(i == w));
      check($sformatf("R3 data dev%0d", i), bd[i], (i == w) ? m_vec[i] : 8'h00);
      check($sformatf("R10 ack_out dev%0d", i), ao[i], !(i < w));
    end
    ack_src = 1;
    step();
    check("R8 oe released", oe[0], 0);
    check("R8 dtack_n released", dtn[0], 1);
    check("R8 ack_out released", ao[0], 1);
    step(); step(); step();
    for (int i = 0; i < 3; i++) begin
      check($sformatf("R8 oe idle dev%0d", i), oe[i], 0);
      check($sformatf("R9 data idle dev%0d", i), bd[i], 0);
      check($sformatf("R2 pend kept dev%0d", i), reqn[i], !m_pend[i]);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 3; i++) begin m_pend[i] = 0; m_vec[i] = 8'h0F; wd[i] = 0; end
    @(negedge clk); step(); step();
    rst_n = 1;
    step();
    for (int i = 0; i < 3; i++) begin
      check("R1 req_n", reqn[i], 1);
      check("R1 ack_out_n", ao[i], 1);
      check("R1 oe", oe[i], 0);
      check("R1 dtack_n", dtn[i], 1);
      check("R1 data", bd[i], 0);
    end
    // R4: unwritten vector claims with 0x0F
    pulse(0, 1, 0);
    do_ack();
    check("R4 uninit vector", m_vec[0], 8'h0F);
    pulse(0, 0, 1);
    // R2: raise and clear together, raise wins
    pulse(1, 1, 1);
    check("R2 raise beats clear", reqn[1], 0);
    write_vec(1, 8'h7A);
    do_ack();
    // no requester: acknowledge leaves the chain (R10)
    pulse(1, 0, 1);
    do_ack();
    // R7: raise mid-pass does not start a claim
    ack_src = 0;
    step(); step(); step();
    pulse(1, 1, 0);
    step();
    check("R7 pass held dev1", ao[1], 0);
    check("R7 no claim dev1", oe[1], 0);
    ack_src = 1;
    step(); step(); step(); step();
    do_ack();
    // R7/R9: clear and rewrite during a claim
    pulse(1, 0, 1);
    write_vec(2, 8'hC3);
    pulse(2, 1, 0);
    ack_src = 0;
    step(); step(); step();
    clr[2] = 1; wen[2] = 1; wd[2] = 8'h11;
    step();
    clr[2] = 0; wen[2] = 0;
    m_pend[2] = 0; m_vec[2] = 8'h11;
    check("R7 claim held after clear", oe[2], 1);
    check("R9 data stable on rewrite", bd[2], 8'hC3);
    ack_src = 1;
    step(); step(); step(); step();
    check("R3 rewritten vector pending off", reqn[2], 1);
    pulse(2, 1, 0);
    do_ack();
    pulse(2, 0, 1);
    // random mix
    for (int k = 0; k < 60; k++) begin
      int d = $urandom_range(0, 2);
      int op = $urandom_range(0, 3);
      if (op == 0) write_vec(d, 8'($urandom));
      else if (op == 1) pulse(d, 1, 0);
      else if (op == 2) pulse(d, 0, 1);
      else do_ack();
    end
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule